// File: doc/BRIEF.md
# Byte-Validated Store Cache

This block is a small set-associative cache that sits in front of a lower-level cache and soaks up store traffic. A store that misses claims a line at once, without fetching anything from below; the block records, byte by byte, which bytes of the line have really been written. Further stores to a resident line merge into it. Only when a line has to leave the cache, on replacement or on a flush, does the block decide whether the lower level must be read. A line whose every byte was written goes straight out as a writeback. A line with holes first reads the lower level, fills the holes and then goes out.

Because the block holds the only on-chip copy of dirty store data, other on-chip caches that fetch a line from the lower level pass that fill through this block. A byte-wise multiplexer replaces each fill byte with the stored byte wherever this cache holds a valid copy. A flush request writes back every resident line in a fixed order. An invalidate-all input throws away all contents without writing anything back.

The default geometry is 8 sets of 4 ways with 64-byte lines (2 Kbytes) and 8-byte store beats.

Top module: `bytewise_write_cache`

## Requirements
- R1: After reset no line is resident: rd_valid, wb_valid, lf_out_valid and flush_busy are low, and st_ready is high for any address because every way is free.
- R2: A store that misses while its set has a free way is accepted in the same cycle. It claims the lowest-numbered free way and issues no lower-level read (rd_valid stays low). Only the bytes it enables become valid. Address bits [8:6] select the set, bits [5:3] select the 8-byte beat within the line, and st_be bit i enables line byte beat*8+i, carried on st_data[8i+7:8i].
- R3: A store that hits a resident line is accepted in the same cycle and merges into it. Bytes it enables take the new data, and bytes already valid keep their value unless rewritten.
- R4: Replacement is least-recently-used per set. Every accepted store, hit or allocation, makes its way the most recent. A store that misses in a full set evicts the least recent way.
- R5: An evicted line whose 64 bytes are all valid is written back without any lower-level read.
- R6: An evicted line with invalid bytes first raises rd_valid with its line address. Once the read is accepted, the block takes the next fill_valid beat and writes back a line holding cache bytes where valid and fill bytes elsewhere. Line byte b is carried on bits [8b+7:8b] of every line-wide bus, and line addresses have bits [5:0] zero.
- R7: A store that needs an eviction is held (st_ready low) until the writeback handshake completes. It is then accepted into the way just freed.
- R8: A lower-level fill on the lf_* port appears on lf_out_* exactly one cycle later. Each byte is replaced by the cached byte wherever that line is resident and the byte is valid, and passes unchanged otherwise.
- R9: A flush request given while idle raises flush_busy and writes back every resident line in ascending set order, ways ascending within a set, with the same read rule as R5 and R6. It then drops flush_busy and leaves the cache empty. Stores are held while flush_busy is high.
- R10: Invalidate-all given while idle empties the cache without any writeback or lower-level read. Afterwards fills pass through unchanged.
- R11: While rd_valid or wb_valid waits for its ready, it stays high and its address and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle when st_valid is high |
| st_addr | input | 32 | Store byte address, 8-byte aligned |
| st_data | input | 64 | Store data |
| st_be | input | 8 | Store byte enables |
| rd_valid | output | 1 | Lower-level line read request |
| rd_ready | input | 1 | Lower level accepts the read |
| rd_addr | output | 32 | Line address of the read |
| fill_valid | input | 1 | Read data beat for the pending eviction |
| fill_data | input | 512 | Line data from the lower level |
| wb_valid | output | 1 | Writeback line valid |
| wb_ready | input | 1 | Writeback accepted |
| wb_addr | output | 32 | Line address of the writeback |
| wb_data | output | 512 | Complete writeback line |
| lf_valid | input | 1 | Fill passing to another cache |
| lf_addr | input | 32 | Address of that fill |
| lf_data | input | 512 | Lower-level data of that fill |
| lf_out_valid | output | 1 | Merged fill valid |
| lf_out_data | output | 512 | Fill with cached bytes overlaid |
| flush_req | input | 1 | Start a flush of all lines |
| flush_busy | output | 1 | Flush walk in progress |
| inv_all | input | 1 | Discard all contents |

## Verification
The bench aims at the boundary between full and partial lines. A line built up from eight full beats must leave with no read, while a single missing byte must trigger one. A design that tested the wrong mask would either waste a read or write back stale holes. It drives the replacement order hard with repeated hits before a conflicting miss, so an update missing on hits or allocations shows up as the wrong line address on the writeback. It also checks fills against partly written lines, the flush order, and the absence of any writeback after invalidate-all, where a design that forgot the per-byte masks or the clearing would leak old bytes.

// File: rtl/wc_pkg.sv
package wc_pkg;
  typedef enum logic [2:0] {
    WC_IDLE    = 3'd0,
    WC_EV_RD   = 3'd1,
    WC_EV_FILL = 3'd2,
    WC_EV_WB   = 3'd3,
    WC_FLUSH   = 3'd4
  } wc_state_e;
endpackage

// File: rtl/wc_rst_sync.sv
module wc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wc_byte_merge.sv
module wc_byte_merge #(
  parameter int NBYTES = 64
) (
  input  logic [NBYTES-1:0]   sel_cache,
  input  logic [NBYTES*8-1:0] cache_line,
  input  logic [NBYTES*8-1:0] lower_line,
  output logic [NBYTES*8-1:0] merged
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    assign merged[b*8 +: 8] = sel_cache[b] ? cache_line[b*8 +: 8] : lower_line[b*8 +: 8];
  end
endmodule

// File: rtl/wc_hit_detect.sv
module wc_hit_detect #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]            way_live,
  input  logic [TAG_W-1:0]           look_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way
);
  logic [WAYS-1:0] match;
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_live[w] && (way_tags[w] == look_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
  assign hit = |match;
endmodule

// File: rtl/wc_lru.sv
module wc_lru #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int AGE_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic [SET_W-1:0] query_set,
  output logic [WAY_W-1:0] victim_way
);
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic [AGE_W-1:0] age_d [SETS][WAYS];

  always_comb begin
    age_d = age_q;
    if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == touch_way)
          age_d[touch_set][w] = '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_d[touch_set][w] = age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= AGE_W'(w);
    end else if (touch_en) begin
      age_q <= age_d;
    end
  end

  always_comb begin
    victim_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_q[query_set][w] == AGE_W'(WAYS-1)) victim_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/bytewise_write_cache.sv
module bytewise_write_cache
  import wc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 8,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  parameter int SB         = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    st_valid,
  output logic                    st_ready,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [SB*8-1:0]         st_data,
  input  logic [SB-1:0]           st_be,
  output logic                    rd_valid,
  input  logic                    rd_ready,
  output logic [ADDR_W-1:0]       rd_addr,
  input  logic                    fill_valid,
  input  logic [LINE_BYTES*8-1:0] fill_data,
  output logic                    wb_valid,
  input  logic                    wb_ready,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic [LINE_BYTES*8-1:0] wb_data,
  input  logic                    lf_valid,
  input  logic [ADDR_W-1:0]       lf_addr,
  input  logic [LINE_BYTES*8-1:0] lf_data,
  output logic                    lf_out_valid,
  output logic [LINE_BYTES*8-1:0] lf_out_data,
  input  logic                    flush_req,
  output logic                    flush_busy,
  input  logic                    inv_all
);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int SET_W     = $clog2(SETS);
  localparam int WAY_W     = $clog2(WAYS);
  localparam int TAG_W     = ADDR_W - OFF_W - SET_W;
  localparam int BEAT_LO   = $clog2(SB);
  localparam int CH_W      = OFF_W - BEAT_LO;
  localparam int IDX_W     = SET_W + WAY_W;
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SETS*WAYS-1);

  logic rst_n_i;
  wc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // storage
  logic [LINE_BITS-1:0]  line_q [SETS][WAYS];
  logic [LINE_BYTES-1:0] bv_q   [SETS][WAYS];
  logic [TAG_W-1:0]      tag_q  [SETS][WAYS];
  logic [WAYS-1:0]       tv_q   [SETS];

  // control state
  wc_state_e        state_q, state_d;
  logic [SET_W-1:0] ev_set_q, ev_set_d;
  logic [WAY_W-1:0] ev_way_q, ev_way_d;
  logic [IDX_W-1:0] fl_idx_q, fl_idx_d;
  logic             from_fl_q, from_fl_d;

  // store-side decode
  logic [SET_W-1:0] st_set;
  logic [TAG_W-1:0] st_tag;
  logic [CH_W-1:0]  st_chunk;
  assign st_set   = st_addr[OFF_W +: SET_W];
  assign st_tag   = st_addr[ADDR_W-1 -: TAG_W];
  assign st_chunk = st_addr[BEAT_LO +: CH_W];

  logic [WAYS-1:0][TAG_W-1:0] st_tags, lf_tags;
  logic [SET_W-1:0] lf_set;
  logic [TAG_W-1:0] lf_tag;
  assign lf_set = lf_addr[OFF_W +: SET_W];
  assign lf_tag = lf_addr[ADDR_W-1 -: TAG_W];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      st_tags[w] = tag_q[st_set][w];
      lf_tags[w] = tag_q[lf_set][w];
    end
  end

  logic             st_hit, lf_hit;
  logic [WAY_W-1:0] st_hit_way, lf_hit_way;

  wc_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_st_hit (
    .way_tags(st_tags), .way_live(tv_q[st_set]), .look_tag(st_tag),
    .hit(st_hit), .hit_way(st_hit_way)
  );
  wc_hit_detect #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lf_hit (
    .way_tags(lf_tags), .way_live(tv_q[lf_set]), .look_tag(lf_tag),
    .hit(lf_hit), .hit_way(lf_hit_way)
  );

  // lowest free way in the store's set
  logic             st_free;
  logic [WAY_W-1:0] st_free_way;
  always_comb begin
    st_free_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (!tv_q[st_set][w]) st_free_way = WAY_W'(w);
    end
  end
  assign st_free = ~&tv_q[st_set];

  logic             idle, ctrl_hold, st_ok, st_fire, st_alloc;
  logic [WAY_W-1:0] st_way, lru_victim;
  logic [LINE_BYTES-1:0] st_mask;

  assign idle      = (state_q == WC_IDLE);
  assign ctrl_hold = inv_all || flush_req;
  assign st_ok     = st_hit || st_free;
  assign st_ready  = idle && !ctrl_hold && st_ok;
  assign st_fire   = st_valid && st_ready;
  assign st_alloc  = !st_hit;
  assign st_way    = st_hit ? st_hit_way : st_free_way;
  assign st_mask   = LINE_BYTES'(st_be) << (int'(st_chunk) * SB);

  wc_lru #(.SETS(SETS), .WAYS(WAYS)) u_lru (
    .clk(clk), .rst_n(rst_n_i),
    .touch_en(st_fire), .touch_set(st_set), .touch_way(st_way),
    .query_set(st_set), .victim_way(lru_victim)
  );

  // flush walk position: set in upper bits, way in lower bits
  logic [SET_W-1:0] fl_set;
  logic [WAY_W-1:0] fl_way;
  assign fl_set = fl_idx_q[IDX_W-1 -: SET_W];
  assign fl_way = fl_idx_q[WAY_W-1:0];

  logic fill_wr, wb_done, inv_go;

  always_comb begin
    state_d   = state_q;
    ev_set_d  = ev_set_q;
    ev_way_d  = ev_way_q;
    fl_idx_d  = fl_idx_q;
    from_fl_d = from_fl_q;
    fill_wr   = 1'b0;
    wb_done   = 1'b0;
    inv_go    = 1'b0;
    unique case (state_q)
      WC_IDLE: begin
        if (inv_all) begin
          inv_go = 1'b1;
        end else if (flush_req) begin
          state_d   = WC_FLUSH;
          fl_idx_d  = '0;
          from_fl_d = 1'b1;
        end else if (st_valid && !st_ok) begin
          ev_set_d  = st_set;
          ev_way_d  = lru_victim;
          from_fl_d = 1'b0;
          state_d   = (&bv_q[st_set][lru_victim]) ? WC_EV_WB : WC_EV_RD;
        end
      end
      WC_EV_RD: begin
        if (rd_ready) state_d = WC_EV_FILL;
      end
      WC_EV_FILL: begin
        if (fill_valid) begin
          fill_wr = 1'b1;
          state_d = WC_EV_WB;
        end
      end
      WC_EV_WB: begin
        if (wb_ready) begin
          wb_done = 1'b1;
          if (!from_fl_q) begin
            state_d = WC_IDLE;
          end else if (fl_idx_q == LAST_IDX) begin
            state_d   = WC_IDLE;
            from_fl_d = 1'b0;
          end else begin
            fl_idx_d = fl_idx_q + 1'b1;
            state_d  = WC_FLUSH;
          end
        end
      end
      WC_FLUSH: begin
        if (tv_q[fl_set][fl_way]) begin
          ev_set_d = fl_set;
          ev_way_d = fl_way;
          state_d  = (&bv_q[fl_set][fl_way]) ? WC_EV_WB : WC_EV_RD;
        end else if (fl_idx_q == LAST_IDX) begin
          state_d   = WC_IDLE;
          from_fl_d = 1'b0;
        end else begin
          fl_idx_d = fl_idx_q + 1'b1;
        end
      end
      default: state_d = WC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q   <= WC_IDLE;
      ev_set_q  <= '0;
      ev_way_q  <= '0;
      fl_idx_q  <= '0;
      from_fl_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ev_set_q  <= ev_set_d;
      ev_way_q  <= ev_way_d;
      fl_idx_q  <= fl_idx_d;
      from_fl_q <= from_fl_d;
    end
  end

  // eviction merge path
  logic [LINE_BITS-1:0] ev_line, ev_merged;
  logic [ADDR_W-1:0]    ev_line_addr;
  assign ev_line      = line_q[ev_set_q][ev_way_q];
  assign ev_line_addr = {tag_q[ev_set_q][ev_way_q], ev_set_q, {OFF_W{1'b0}}};

  wc_byte_merge #(.NBYTES(LINE_BYTES)) u_ev_merge (
    .sel_cache(bv_q[ev_set_q][ev_way_q]), .cache_line(ev_line),
    .lower_line(fill_data), .merged(ev_merged)
  );

  assign rd_valid   = (state_q == WC_EV_RD);
  assign rd_addr    = ev_line_addr;
  assign wb_valid   = (state_q == WC_EV_WB);
  assign wb_addr    = ev_line_addr;
  assign wb_data    = ev_line;
  assign flush_busy = from_fl_q;

  // valid bits
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int s = 0; s < SETS; s++) begin
        tv_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) bv_q[s][w] <= '0;
      end
    end else begin
      if (inv_go) begin
        for (int s = 0; s < SETS; s++) begin
          tv_q[s] <= '0;
          for (int w = 0; w < WAYS; w++) bv_q[s][w] <= '0;
        end
      end
      if (st_fire) begin
        tv_q[st_set][st_way] <= 1'b1;
        bv_q[st_set][st_way] <= st_alloc ? st_mask : (bv_q[st_set][st_way] | st_mask);
      end
      if (fill_wr) bv_q[ev_set_q][ev_way_q] <= '1;
      if (wb_done) begin
        tv_q[ev_set_q][ev_way_q] <= 1'b0;
        bv_q[ev_set_q][ev_way_q] <= '0;
      end
    end
  end

  // tags and line data, enable-only
  always_ff @(posedge clk) begin
    if (st_fire && st_alloc) tag_q[st_set][st_way] <= st_tag;
  end

  always_ff @(posedge clk) begin
    if (st_fire) begin
      for (int b = 0; b < SB; b++) begin
        if (st_be[b])
          line_q[st_set][st_way][(int'(st_chunk)*SB + b)*8 +: 8] <= st_data[b*8 +: 8];
      end
    end
    if (fill_wr) line_q[ev_set_q][ev_way_q] <= ev_merged;
  end

  // pass-through fill merge
  logic [LINE_BYTES-1:0] lf_sel;
  logic [LINE_BITS-1:0]  lf_merged;
  logic                  lf_out_valid_q;
  logic [LINE_BITS-1:0]  lf_out_data_q;
  assign lf_sel = lf_hit ? bv_q[lf_set][lf_hit_way] : '0;

  wc_byte_merge #(.NBYTES(LINE_BYTES)) u_lf_merge (
    .sel_cache(lf_sel), .cache_line(line_q[lf_set][lf_hit_way]),
    .lower_line(lf_data), .merged(lf_merged)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) lf_out_valid_q <= 1'b0;
    else          lf_out_valid_q <= lf_valid;
  end
  always_ff @(posedge clk) begin
    if (lf_valid) lf_out_data_q <= lf_merged;
  end
  assign lf_out_valid = lf_out_valid_q;
  assign lf_out_data  = lf_out_data_q;

  logic unused_addr_bits;
  assign unused_addr_bits = ^{st_addr[BEAT_LO-1:0], lf_addr[OFF_W-1:0]};
endmodule

// File: rtl/wc_chk.sv
module wc_chk #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 st_ready,
  input logic                 rd_valid,
  input logic                 rd_ready,
  input logic [ADDR_W-1:0]    rd_addr,
  input logic                 wb_valid,
  input logic                 wb_ready,
  input logic [ADDR_W-1:0]    wb_addr,
  input logic [LINE_BITS-1:0] wb_data,
  input logic                 lf_valid,
  input logic                 lf_out_valid,
  input logic                 flush_busy
);
  // R11
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr) && $stable(wb_data));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
  // R7
  st_hold_evict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid || rd_valid) |-> !st_ready);
  // R9
  st_hold_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !st_ready);
  // R6
  rd_wb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wb_valid));
  // R6
  fill_before_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready |=> !wb_valid);
  // R8
  lf_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lf_valid |=> lf_out_valid);
  // R8
  lf_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lf_valid |=> !lf_out_valid);
endmodule

bind bytewise_write_cache wc_chk #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BYTES*8)) u_wc_chk (
  .clk(clk), .rst_n(rst_n_i), .st_ready(st_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
  .lf_valid(lf_valid), .lf_out_valid(lf_out_valid), .flush_busy(flush_busy)
);

// File: tb/tb_bytewise_write_cache.sv
`timescale 1ns/1ps
module tb_bytewise_write_cache;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic         st_valid, st_ready;
  logic [31:0]  st_addr;
  logic [63:0]  st_data;
  logic [7:0]   st_be;
  logic         rd_valid, rd_ready;
  logic [31:0]  rd_addr;
  logic         fill_valid;
  logic [511:0] fill_data;
  logic         wb_valid, wb_ready;
  logic [31:0]  wb_addr;
  logic [511:0] wb_data;
  logic         lf_valid;
  logic [31:0]  lf_addr;
  logic [511:0] lf_data;
  logic         lf_out_valid;
  logic [511:0] lf_out_data;
  logic         flush_req, flush_busy, inv_all;

  bytewise_write_cache dut (.*);

  int n_chk = 0, n_bad = 0;
  int rd_cnt = 0, exp_rd = 0, wb_cnt = 0;

  // reference model
  logic [7:0]  m_data [8][4][64];
  logic [63:0] m_bv   [8][4];
  logic [22:0] m_tag  [8][4];
  logic        m_tv   [8][4];
  int          m_age  [8][4];
  logic [31:0]  q_addr [$];
  logic [511:0] q_data [$];
  string        q_req  [$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] lower_byte(input logic [31:0] a);
    return a[7:0] ^ a[14:7] ^ 8'h5A;
  endfunction

  function automatic logic [511:0] lower_line(input logic [31:0] la);
    logic [511:0] d;
    for (int b = 0; b < 64; b++) d[b*8 +: 8] = lower_byte(la + 32'(b));
    return d;
  endfunction

  task automatic m_touch(input int s, input int w);
    int a0 = m_age[s][w];
    for (int v = 0; v < 4; v++) if (m_age[s][v] < a0) m_age[s][v]++;
    m_age[s][w] = 0;
  endtask

  task automatic m_evict(input int s, input int w, input string req);
    logic [31:0]  la;
    logic [511:0] d;
    la = {m_tag[s][w], 3'(s), 6'b0};
    for (int b = 0; b < 64; b++)
      d[b*8 +: 8] = m_bv[s][w][b] ? m_data[s][w][b] : lower_byte(la + 32'(b));
    if (m_bv[s][w] != '1) exp_rd++;
    q_addr.push_back(la); q_data.push_back(d); q_req.push_back(req);
    m_tv[s][w] = 1'b0; m_bv[s][w] = '0;
  endtask

  function automatic logic [511:0] exp_lf(input logic [31:0] a, input logic [511:0] low);
    logic [511:0] d = low;
    int s = int'(a[8:6]);
    for (int w = 0; w < 4; w++)
      if (m_tv[s][w] && m_tag[s][w] == a[31:9])
        for (int b = 0; b < 64; b++)
          if (m_bv[s][w][b]) d[b*8 +: 8] = m_data[s][w][b];
    return d;
  endfunction

  // lower level and writeback responder
  logic        pend_fill = 1'b0;
  logic [31:0] pend_addr;
  logic        prev_wb_stall = 1'b0, prev_rd_stall = 1'b0;
  logic [31:0] prev_wb_addr, prev_rd_addr;
  initial begin
    rd_ready = 1'b0; wb_ready = 1'b0; fill_valid = 1'b0; fill_data = '0;
    forever begin
      @(negedge clk);
      #0.5;
      if (pend_fill) begin
        fill_valid = 1'b1; fill_data = lower_line(pend_addr); pend_fill = 1'b0;
      end else begin
        fill_valid = 1'b0;
      end
      rd_ready = ($urandom % 3) != 0;
      wb_ready = ($urandom % 4) != 0;
      #0.5;
      if (prev_wb_stall) chk(wb_valid && wb_addr == prev_wb_addr, "R11", "wb held", {480'b0, wb_addr}, {480'b0, prev_wb_addr});
      if (prev_rd_stall) chk(rd_valid && rd_addr == prev_rd_addr, "R11", "rd held", {480'b0, rd_addr}, {480'b0, prev_rd_addr});
      prev_wb_stall = wb_valid && !wb_ready; prev_wb_addr = wb_addr;
      prev_rd_stall = rd_valid && !rd_ready; prev_rd_addr = rd_addr;
      if (rd_valid && rd_ready) begin
        rd_cnt++;
        chk(q_addr.size() > 0 && rd_addr == q_addr[0], "R6", "read line address",
            {480'b0, rd_addr}, {480'b0, (q_addr.size() > 0) ? q_addr[0] : 32'hX});
        pend_fill = 1'b1; pend_addr = rd_addr;
      end
      if (wb_valid && wb_ready) begin
        wb_cnt++;
        if (q_addr.size() == 0) begin
          chk(1'b0, "R10", "unexpected writeback", {480'b0, wb_addr}, '0);
        end else begin
          chk(wb_addr == q_addr[0], "R4", {q_req[0], " writeback address"}, {480'b0, wb_addr}, {480'b0, q_addr[0]});
          chk(wb_data == q_data[0], q_req[0], "writeback data", wb_data, q_data[0]);
          void'(q_addr.pop_front()); void'(q_data.pop_front()); void'(q_req.pop_front());
        end
      end
    end
  end

  task automatic do_store(input logic [22:0] tag, input int s, input int ch,
                          input logic [63:0] d, input logic [7:0] be);
    int w = -1, waits = 0;
    bit ev = 0, full = 0;
    string req;
    for (int v = 0; v < 4; v++) if (w < 0 && m_tv[s][v] && m_tag[s][v] == tag) w = v;
    if (w < 0) begin
      for (int v = 3; v >= 0; v--) if (!m_tv[s][v]) w = v;
      if (w < 0) begin
        for (int v = 0; v < 4; v++) if (m_age[s][v] == 3) w = v;
        ev = 1; full = (m_bv[s][w] == '1);
        m_evict(s, w, full ? "R5" : "R6");
      end
      m_tv[s][w] = 1'b1; m_tag[s][w] = tag; m_bv[s][w] = '0;
    end
    for (int b = 0; b < 8; b++)
      if (be[b]) begin m_data[s][w][ch*8+b] = d[b*8 +: 8]; m_bv[s][w][ch*8+b] = 1'b1; end
    m_touch(s, w);
    @(negedge clk);
    st_valid = 1'b1; st_addr = {tag, 3'(s), 3'(ch), 3'b0}; st_data = d; st_be = be;
    #1;
    while (!st_ready && waits < 2000) begin @(negedge clk); #1; waits++; end
    @(posedge clk); #1 st_valid = 1'b0;
    req = !ev ? "R2" : (full ? "R5" : "R6");
    chk((waits > 0) == ev, ev ? "R7" : "R2", "store stall cycles", 512'(waits), 512'(ev));
    chk(rd_cnt == exp_rd, req, "lower read count", 512'(rd_cnt), 512'(exp_rd));
  endtask

  task automatic do_lf(input logic [31:0] a, input logic [511:0] low, input string req);
    logic [511:0] e;
    @(negedge clk);
    lf_valid = 1'b1; lf_addr = a; lf_data = low;
    @(posedge clk); #1 lf_valid = 1'b0;
    e = exp_lf(a, low);
    @(negedge clk); #1;
    chk(lf_out_valid && lf_out_data == e, req, "merged fill", lf_out_data, e);
  endtask

  task automatic do_flush();
    int t = 0;
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++)
        if (m_tv[s][w]) m_evict(s, w, "R9");
    @(negedge clk); flush_req = 1'b1;
    @(posedge clk); #1 flush_req = 1'b0;
    @(negedge clk); #1;
    while (flush_busy && t < 5000) begin @(negedge clk); #1; t++; end
    chk(!flush_busy && q_addr.size() == 0, "R9", "flush done, pending lines", 512'(q_addr.size()), 512'(0));
    chk(rd_cnt == exp_rd, "R9", "flush read count", 512'(rd_cnt), 512'(exp_rd));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int wb0;
    void'($urandom(32'd4242));
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0;
    lf_valid = 0; lf_addr = 0; lf_data = 0; flush_req = 0; inv_all = 0;
    for (int s = 0; s < 8; s++)
      for (int w = 0; w < 4; w++) begin m_tv[s][w] = 0; m_bv[s][w] = 0; m_age[s][w] = w; end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    // R1 reset state
    chk(!rd_valid && !wb_valid && !lf_out_valid && !flush_busy, "R1", "outputs idle",
        {508'b0, rd_valid, wb_valid, lf_out_valid, flush_busy}, '0);
    chk(st_ready, "R1", "st_ready with empty cache", 512'(st_ready), 512'(1));

    // R2 miss allocates partial line, R8 merge
    do_store(23'd1, 0, 2, 64'h1122334455667788, 8'h0F);
    do_lf({23'd1, 3'd0, 6'd0}, {16{32'hCAFEF00D}}, "R8");
    // R3 hit merge over existing bytes
    do_store(23'd1, 0, 2, 64'hA1A2A3A4B1B2B3B4, 8'hF0);
    do_store(23'd1, 0, 2, 64'h0000000000EE0000, 8'h04);
    do_lf({23'd1, 3'd0, 6'd0}, {16{32'h01234567}}, "R3");
    // R4 LRU: fill set 0, touch tag 1, conflicting miss evicts tag 2 (partial, R6)
    do_store(23'd2, 0, 0, 64'h5555, 8'h03);
    do_store(23'd3, 0, 7, 64'h6666, 8'h80);
    do_store(23'd4, 0, 1, 64'h7777, 8'hFF);
    do_store(23'd1, 0, 3, 64'h8888, 8'h01);
    do_store(23'd5, 0, 4, 64'h9999, 8'h10);
    do_lf({23'd2, 3'd0, 6'd0}, {16{32'h13572468}}, "R4");
    // R5 fully written line evicted with no read
    for (int c = 0; c < 8; c++) do_store(23'd9, 1, c, {$urandom, $urandom}, 8'hFF);
    do_store(23'd10, 1, 0, 64'h1, 8'h01);
    do_store(23'd11, 1, 0, 64'h2, 8'h01);
    do_store(23'd12, 1, 0, 64'h3, 8'h01);
    do_store(23'd13, 1, 0, 64'h4, 8'h01);
    // one byte short of full: read needed
    for (int c = 0; c < 8; c++) do_store(23'd20, 2, c, {$urandom, $urandom}, (c == 5) ? 8'hBF : 8'hFF);
    for (int t = 21; t < 25; t++) do_store(23'(t), 2, 1, 64'hF, 8'h02);

    // R10 invalidate-all: no writeback, fills pass unchanged
    wb0 = wb_cnt;
    @(negedge clk); inv_all = 1'b1;
    @(posedge clk); #1 inv_all = 1'b0;
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) begin m_tv[s][w] = 0; m_bv[s][w] = 0; end
    repeat (5) @(negedge clk);
    chk(wb_cnt == wb0 && rd_cnt == exp_rd, "R10", "writebacks after invalidate", 512'(wb_cnt), 512'(wb0));
    do_lf({23'd5, 3'd0, 6'd0}, {16{32'h89ABCDEF}}, "R10");
    do_lf({23'd13, 3'd1, 6'd0}, {16{32'h0F1E2D3C}}, "R10");

    // R9 flush order across sets and ways
    do_store(23'd30, 3, 0, 64'hAB, 8'h01);
    do_store(23'd31, 3, 6, 64'hCD, 8'h02);
    do_store(23'd32, 6, 2, 64'hEF, 8'hFF);
    do_store(23'd33, 0, 1, 64'h12, 8'h0C);
    do_flush();
    do_lf({23'd30, 3'd3, 6'd0}, {16{32'h55AA55AA}}, "R9");

    // random traffic
    for (int i = 0; i < 700; i++) begin
      logic [7:0] be;
      be = 8'($urandom);
      if (be == 0) be = 8'h01;
      do_store(23'($urandom % 6), int'($urandom % 8), int'($urandom % 8), {$urandom, $urandom}, be);
      if (i % 40 == 0)
        do_lf({23'($urandom % 6), 3'($urandom % 8), 6'd0}, {$urandom, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
              $urandom, $urandom, $urandom, $urandom}, "R8");
      if (i % 250 == 249) do_flush();
    end
    do_flush();
    finish_run();
  end
endmodule